// File: doc/BRIEF.md
# Daisy-Chain Bus Arbiter

This block is the central arbiter for a set of devices that share one bus. Every device's request is ORed onto a single request line. The arbiter answers with one grant signal, which enters the device nearest to it and moves through the devices in chain order. The first device on the chain that is requesting keeps the grant and stops it from travelling further. Devices farther down never see it.

Once a device holds the bus, it keeps it until it signals completion on a shared release line. The arbiter then withdraws the grant. It holds the grant low for at least one cycle and only then answers the next request. Priority comes only from position: the device nearest the arbiter always wins. As a result, a far device can be locked out for as long as nearer devices keep asking. A device that starts requesting while the bus is held cannot take it from the owner, and it waits for the next grant.

Top module: `busChainArbiter`

## Requirements
- R1: After reset, `busGrant`, `devGranted` and `chainTail` are all zero.
- R2: When any bit of `devReq` is high while the arbiter is idle, `busGrant` goes high on the following cycle.
- R3: In the first grant cycle, exactly the lowest-index requesting device is granted. Bit 0 is the device nearest the arbiter and has the highest priority.
- R4: If no device is requesting when the grant enters the chain, the grant reaches `chainTail`, and the arbiter drops `busGrant` on the next cycle.
- R5: While the bus is held, the owner stays granted even if a higher-priority device starts requesting.
- R6: A `devDone` bit from a device that does not own the bus has no effect on ownership.
- R7: When the owner raises its `devDone` bit, `busGrant` is low on the next cycle. It stays low for at least one cycle before the next grant.
- R8: A device that requests continuously wins every round against any device of higher index. The device at the far end is never granted while bit 0 keeps requesting.
- R9: At most one bit of `devGranted` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devReq | input | NUM_DEV | Per-device request, merged into one OR line |
| devDone | input | NUM_DEV | Per-device completion, only the owner's bit drives release |
| busGrant | output | 1 | Grant driven into the nearest device |
| devGranted | output | NUM_DEV | Per-device grant held (one-hot or zero) |
| chainTail | output | 1 | Grant leaving the last device of the chain |

## Verification
Directed patterns use two requesters at once to check that the nearer one wins. A nearer request raised during ownership tells a correct hold apart from preemption. A completion from a non-owner tells a shared release that is correctly gated apart from one that is not. A request that is withdrawn before the grant arrives exercises the run to the chain tail. A long run with bit 0 and the last device both requesting shows that the far device is starved. Random request and completion patterns are then compared every cycle against a reference model in the bench. These cover back-to-back rounds and requests that drop at any point.

// File: rtl/chainArbPkg.sv
package chainArbPkg;
  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_GRANT = 2'd1,
    ARB_HOLD  = 2'd2
  } arbState_t;

  typedef struct packed {
    logic grantOn;  // drive grant into the chain
    logic capture;  // cells latch ownership this cycle
    logic lock;     // ownership frozen, requests ignored
    logic clear;    // drop ownership at this edge
  } arbStrobe_t;
endpackage

// File: rtl/chainArbCtrl.sv
module chainArbCtrl
  import chainArbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyReq,
  input  logic       releaseLine,
  input  logic       tailGrant,
  output arbStrobe_t strobes
);
  arbState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ARB_IDLE:  if (anyReq) stateNext = ARB_GRANT;
      ARB_GRANT: stateNext = tailGrant ? ARB_IDLE : ARB_HOLD;
      ARB_HOLD:  if (releaseLine) stateNext = ARB_IDLE;
      default:   stateNext = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ARB_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobes.grantOn = (state != ARB_IDLE);
    strobes.capture = (state == ARB_GRANT);
    strobes.lock    = (state == ARB_HOLD);
    strobes.clear   = (state == ARB_HOLD) && releaseLine;
  end

  // R2
  idle_req_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ARB_IDLE && anyReq) |=> strobes.grantOn);

  // R7
  release_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ARB_HOLD && releaseLine) |=> !strobes.grantOn);

  // R4
  tail_return_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ARB_GRANT && tailGrant) |=> (state == ARB_IDLE));
endmodule

// File: rtl/chainArbCell.sv
module chainArbCell
  import chainArbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  arbStrobe_t strobes,
  input  logic       reqIn,
  input  logic       doneIn,
  input  logic       grantIn,
  output logic       grantOut,
  output logic       granted,
  output logic       relOut
);
  logic ownedQ;
  logic absorb;

  always_ff @(posedge clk) begin
    if (!rstN)                ownedQ <= 1'b0;
    else if (strobes.clear)   ownedQ <= 1'b0;
    else if (strobes.capture) ownedQ <= grantIn & reqIn;
  end

  // while locked, only the latched owner keeps the grant
  assign absorb   = strobes.lock ? ownedQ : reqIn;
  assign granted  = grantIn & absorb;
  assign grantOut = grantIn & ~absorb;
  assign relOut   = granted & doneIn;

  // R5
  owner_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.lock && !strobes.clear) |=> $stable(ownedQ));
endmodule

// File: rtl/chainArbPath.sv
module chainArbPath
  import chainArbPkg::*;
#(
  parameter int NUM_DEV = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  arbStrobe_t         strobes,
  input  logic [NUM_DEV-1:0] devReq,
  input  logic [NUM_DEV-1:0] devDone,
  output logic [NUM_DEV-1:0] devGranted,
  output logic               anyReq,
  output logic               releaseLine,
  output logic               tailGrant
);
  localparam int CHAIN_LEN = NUM_DEV + 1;

  logic [CHAIN_LEN-1:0] chain;
  logic [NUM_DEV-1:0]   relBits;

  assign chain[0] = strobes.grantOn;

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_cell
    chainArbCell u_cell (
      .clk      (clk),
      .rstN     (rstN),
      .strobes  (strobes),
      .reqIn    (devReq[i]),
      .doneIn   (devDone[i]),
      .grantIn  (chain[i]),
      .grantOut (chain[i+1]),
      .granted  (devGranted[i]),
      .relOut   (relBits[i])
    );
  end

  assign anyReq      = |devReq;
  assign releaseLine = |relBits;
  assign tailGrant   = chain[CHAIN_LEN-1];

  // R9
  single_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(devGranted));
endmodule

// File: rtl/busChainArbiter.sv
module busChainArbiter
  import chainArbPkg::*;
#(
  parameter int NUM_DEV = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DEV-1:0] devReq,
  input  logic [NUM_DEV-1:0] devDone,
  output logic               busGrant,
  output logic [NUM_DEV-1:0] devGranted,
  output logic               chainTail
);
  arbStrobe_t strobes;
  logic anyReq, releaseLine, tailGrant;

  chainArbCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .anyReq      (anyReq),
    .releaseLine (releaseLine),
    .tailGrant   (tailGrant),
    .strobes     (strobes)
  );

  chainArbPath #(.NUM_DEV(NUM_DEV)) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .devReq      (devReq),
    .devDone     (devDone),
    .devGranted  (devGranted),
    .anyReq      (anyReq),
    .releaseLine (releaseLine),
    .tailGrant   (tailGrant)
  );

  assign busGrant  = strobes.grantOn;
  assign chainTail = tailGrant;
endmodule

// File: tb/sim_busChainArbiter.sv
module sim_busChainArbiter;
  localparam int DEV = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DEV-1:0] devReq = '0;
  logic [DEV-1:0] devDone = '0;
  logic busGrant, chainTail;
  logic [DEV-1:0] devGranted;

  int checks = 0;
  int fails = 0;
  int mSt = 0;
  logic [DEV-1:0] mOwn = '0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  busChainArbiter #(.NUM_DEV(DEV)) u0 (
    .clk(clk), .rstN(rstN), .devReq(devReq), .devDone(devDone),
    .busGrant(busGrant), .devGranted(devGranted), .chainTail(chainTail)
  );

  function automatic logic [DEV-1:0] lowBit(input logic [DEV-1:0] v);
    logic [DEV-1:0] r = '0;
    for (int i = DEV - 1; i >= 0; i--) if (v[i]) r = '0 | (1 << i);
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [DEV-1:0] r, input logic [DEV-1:0] d, input string tag);
    logic eGrant, eTail;
    logic [DEV-1:0] eGranted;
    @(negedge clk);
    devReq = r;
    devDone = d;
    #1;
    eGrant = (mSt != 0);
    eTail = (mSt == 1) && (r == '0);
    eGranted = (mSt == 1) ? lowBit(r) : (mSt == 2) ? mOwn : '0;
    check(tag, {devGranted, busGrant, chainTail}, {eGranted, eGrant, eTail});
    case (mSt)
      0: if (|r) mSt = 1;
      1: if (r == '0) mSt = 0; else begin mOwn = lowBit(r); mSt = 2; end
      default: if (|(d & mOwn)) begin mSt = 0; mOwn = '0; end
    endcase
  endtask

  initial begin
    int lowWins = 0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1", {devGranted, busGrant, chainTail}, '0);
    step('0, '0, "R1");
    // R2 request seen in idle, R3 nearest wins
    step(5'b00110, '0, "R2");
    step(5'b00110, '0, "R3");
    // R5 higher priority request cannot preempt
    step(5'b00111, '0, "R5");
    // R6 done from non-owner ignored
    step(5'b00111, 5'b00001, "R6");
    step(5'b00111, '0, "R6");
    // R7 owner release, grant low one cycle, then re-arbitrate
    step(5'b00101, 5'b00010, "R7");
    step(5'b00101, '0, "R7");
    step(5'b00101, '0, "R3");
    step('0, 5'b00001, "R7");
    step('0, '0, "R7");
    // R4 request withdrawn before grant arrives
    step(5'b01000, '0, "R4");
    step('0, '0, "R4");
    step('0, '0, "R4");
    // R8 far device starved while bit 0 keeps requesting
    for (int k = 0; k < 12; k++) begin
      step(5'b10001, 5'b00001, "R8");
      if (devGranted[DEV-1]) lowWins++;
    end
    check("R8", lowWins, 0);
    step('0, 5'b00001, "R8");
    step('0, '0, "R8");
    // random rounds: R3, R5, R6, R7, R9 against the model
    for (int k = 0; k < 3000; k++) begin
      logic [DEV-1:0] r, d;
      r = DEV'($urandom) & DEV'($urandom);
      d = ($urandom % 4 == 0) ? DEV'($urandom) : '0;
      step(r, d, "R9");
      if ($countones(devGranted) > 1) check("R9", devGranted, lowBit(devGranted));
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule